// File: doc/BRIEF.md
# Non-cacheable address region decoder

The decoder decides, for each 32-bit physical address presented on its lookup port, whether that address must bypass the cache. The decision comes from a small bank of byte-wide configuration registers. Four of the register groups each describe one programmable region: a base address and a power-of-two size. Two enable bits in a mode byte add fixed legacy windows: the low 64 KB of every megabyte, and the 640 KB to 1 MB hole at the bottom of memory.

Software programs the bank one byte at a time through an indexed port (8-bit index, 8-bit data, write strobe). The same index also drives a combinational read-back. Every region is a three-byte group, and each byte can be written on its own. The lookup result is registered. It is the OR of every enabled region hit and both enabled legacy windows, and it appears one clock after the address is sampled.

Top module: `nc_region_decoder`

## Requirements
- R1: After a synchronous active-low reset every register reads back 0x00 and the lookup output is 0 for any address.
- R2: Region k (k = 0..3) occupies indices 0xC4+3k (base bits 31..24), 0xC5+3k (base bits 23..16) and 0xC6+3k (base bits 15..12 in bits 7..4, size code in bits 3..0). A write to one of these indices changes only that byte, and the byte reads back at its index.
- R3: Index 0xC1 stores only its bit 0. Bits 7..1 always read back as zero.
- R4: Writes to any index other than 0xC0, 0xC1 and 0xC4..0xCF change no state. Such indices read back 0x00, and lookups are unaffected.
- R5: A region whose size code is 0 never matches.
- R6: A size code n in 1..14 selects a block of 2^(n+11) bytes. Address bits below that size are ignored in the compare, so the region covers exactly one aligned block that holds the base.
- R7: Size code 15 makes the region match every address.
- R8: When bit 0 of index 0xC0 is set, every address whose bits 19..16 are all zero is non-cacheable.
- R9: When bit 1 of index 0xC0 is set, addresses 0x000A0000 through 0x000FFFFF are non-cacheable. The window does not repeat in higher megabytes.
- R10: The output is the OR of all region hits and both legacy rules. It is registered and reflects the address and configuration sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Byte write strobe |
| cfg_idx | input | 8 | Register index for write and read-back |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Combinational read-back of the byte at cfg_idx |
| lookup_addr | input | 32 | Physical address to classify |
| lookup_uncached | output | 1 | Registered non-cacheable flag for the address sampled one edge earlier |

## Verification
Read-back is combinational, so the bench applies an index after a falling edge and compares cfg_rdata a short delay later, in the same cycle. A byte write takes effect at the next rising edge, and a lookup result appears one rising edge after the address is sampled. The bench therefore holds each address across one rising edge and compares lookup_uncached at the following falling edge. A behavioural model captures its expected flag at every rising edge, using the configuration as it stood before any write at that edge, and that expectation is compared against the output on every falling edge.

// File: rtl/ncd_pkg.sv
// Package: shared constants and types of the non-cacheable region decoder.
// Assumes a 32-bit physical address with 4 KB base granularity.
package ncd_pkg;
    localparam int ADDR_W     = 32;
    localparam int BYTE_W     = 8;
    localparam int PAGE_SHIFT = 12;   // base bits below this are implied zero
    localparam int SIZE_BIAS  = 11;   // code n spans 2^(n+SIZE_BIAS) bytes
    localparam int GROUP_LEN  = 3;    // bytes per region group

    localparam logic [7:0] IDX_MODE   = 8'hC0;  // legacy window enables
    localparam logic [7:0] IDX_AUX    = 8'hC1;  // single defined bit
    localparam logic [7:0] IDX_GROUP0 = 8'hC4;  // first region group

    localparam logic [3:0] CODE_OFF = 4'd0;
    localparam logic [3:0] CODE_ALL = 4'd15;

    // One region group, in index order.
    typedef struct packed {
        logic [7:0] base_top;    // base bits 31..24
        logic [7:0] base_mid;    // base bits 23..16
        logic [7:0] base_code;   // base bits 15..12 | size code
    } region_cfg_t;
endpackage

// File: rtl/ncd_regbank.sv
// Register bank: stores the mode byte, the auxiliary bit and every region
// group byte, accepts single-byte writes by index and returns a combinational
// read-back. Assumes write index and read index share one port.
module ncd_regbank
    import ncd_pkg::*;
#(
    parameter int NUM_REGIONS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [7:0]                    idx,
    input  logic [BYTE_W-1:0]             wdata,
    output logic [BYTE_W-1:0]             rdata,
    output logic                          low64k_en,
    output logic                          hole_en,
    output region_cfg_t [NUM_REGIONS-1:0] region_cfg
);
    localparam int NUM_BYTES = NUM_REGIONS * GROUP_LEN;
    localparam logic [7:0] IDX_LAST = 8'(int'(IDX_GROUP0) + NUM_BYTES - 1);

    logic [BYTE_W-1:0]                 mode_q;
    logic                              aux_q;
    logic [NUM_BYTES-1:0][BYTE_W-1:0]  bytes_q;
    logic                              idx_known;

    // Mode byte storage.
    always_ff @(posedge clk) begin
        if (!rst_n)                         mode_q <= '0;
        else if (wr_en && idx == IDX_MODE)  mode_q <= wdata;
    end

    // Auxiliary register keeps only its defined bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                        aux_q <= 1'b0;
        else if (wr_en && idx == IDX_AUX)  aux_q <= wdata[0];
    end

    genvar k;
    generate
        for (k = 0; k < NUM_BYTES; k++) begin : g_byte
            localparam logic [7:0] MY_IDX = 8'(int'(IDX_GROUP0) + k);

            // One region byte, written only when its own index is addressed.
            always_ff @(posedge clk) begin
                if (!rst_n)                       bytes_q[k] <= '0;
                else if (wr_en && idx == MY_IDX)  bytes_q[k] <= wdata;
            end

            // R2
            byte_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && idx != MY_IDX) |=> $stable(bytes_q[k]))
                else $error("region byte %0d changed on a foreign write", k);
        end

        for (k = 0; k < NUM_REGIONS; k++) begin : g_group
            // Assemble one region group from its three bytes.
            assign region_cfg[k] = '{base_top:  bytes_q[GROUP_LEN*k],
                                     base_mid:  bytes_q[GROUP_LEN*k + 1],
                                     base_code: bytes_q[GROUP_LEN*k + 2]};
        end
    endgenerate

    assign low64k_en = mode_q[0];
    assign hole_en   = mode_q[1];

    // Decode whether the index names any stored register.
    always_comb begin
        idx_known = (idx == IDX_MODE) || (idx == IDX_AUX) ||
                    ((idx >= IDX_GROUP0) && (idx <= IDX_LAST));
    end

    // Read-back multiplexer; unknown indices return zero.
    always_comb begin
        rdata = '0;
        if (idx == IDX_MODE)     rdata = mode_q;
        else if (idx == IDX_AUX) rdata = {{(BYTE_W-1){1'b0}}, aux_q};
        else begin
            for (int j = 0; j < NUM_BYTES; j++) begin
                if (idx == 8'(int'(IDX_GROUP0) + j)) rdata = bytes_q[j];
            end
        end
    end

    // R4
    unknown_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !idx_known) |=> ($stable(bytes_q) && $stable(mode_q) && $stable(aux_q)))
        else $error("write to an unknown index changed state");

    // R3
    aux_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == IDX_AUX) |-> (rdata[BYTE_W-1:1] == '0))
        else $error("reserved auxiliary bits read nonzero");
endmodule

// File: rtl/ncd_region_match.sv
// Region comparator: decides whether an address falls inside the aligned
// power-of-two block described by one region group. Purely combinational.
// Assumes the base is aligned; any base bits below the size are ignored.
module ncd_region_match
    import ncd_pkg::*;
(
    input  region_cfg_t        cfg,
    input  logic [ADDR_W-1:0]  addr,
    output logic               hit
);
    logic [3:0]        code;
    logic [ADDR_W-1:0] base_full;
    logic [ADDR_W-1:0] keep_mask;

    assign code      = cfg.base_code[3:0];
    assign base_full = {cfg.base_top, cfg.base_mid, cfg.base_code[7:4], {PAGE_SHIFT{1'b0}}};

    // Size decode: bits at or above the block size take part in the compare.
    always_comb begin
        if (code == CODE_ALL) keep_mask = '0;
        else                  keep_mask = {ADDR_W{1'b1}} << (int'(code) + SIZE_BIAS);
    end

    // Masked compare gated by the enable code.
    always_comb begin
        hit = (code != CODE_OFF) && (((addr ^ base_full) & keep_mask) == '0);
    end
endmodule

// File: rtl/ncd_legacy_match.sv
// Legacy window comparator: low 64 KB of each megabyte, and the fixed
// 640 KB..1 MB hole at the bottom of memory. Combinational; takes only the
// address bits at and above bit 16 since neither window is finer.
module ncd_legacy_match (
    input  logic        low64k_en,
    input  logic        hole_en,
    input  logic [15:0] addr_hi,     // address bits 31..16
    output logic        low64k_hit,
    output logic        hole_hit
);
    // Low 64 KB of any megabyte: bits 19..16 all zero.
    always_comb low64k_hit = low64k_en && (addr_hi[3:0] == 4'h0);

    // Absolute window 0x000A0000..0x000FFFFF.
    always_comb hole_hit = hole_en && (addr_hi[15:4] == 12'h000) && (addr_hi[3:0] >= 4'hA);
endmodule

// File: rtl/nc_region_decoder.sv
// Top: programmable non-cacheable region decoder. Holds the configuration
// bank, compares the lookup address against every region and both legacy
// windows, and registers the combined flag. Assumes cfg_idx is stable
// around the rising edge whenever cfg_wr_en is high.
module nc_region_decoder
    import ncd_pkg::*;
#(
    parameter int NUM_REGIONS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr_en,
    input  logic [7:0]         cfg_idx,
    input  logic [BYTE_W-1:0]  cfg_wdata,
    output logic [BYTE_W-1:0]  cfg_rdata,
    input  logic [ADDR_W-1:0]  lookup_addr,
    output logic               lookup_uncached
);
    region_cfg_t [NUM_REGIONS-1:0] region_cfg;
    logic [NUM_REGIONS-1:0]        region_hit;
    logic                          low64k_en, hole_en;
    logic                          low64k_hit, hole_hit;
    logic                          any_region_hit;
    logic                          uncached_d;

    ncd_regbank #(.NUM_REGIONS(NUM_REGIONS)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr_en),
        .idx        (cfg_idx),
        .wdata      (cfg_wdata),
        .rdata      (cfg_rdata),
        .low64k_en  (low64k_en),
        .hole_en    (hole_en),
        .region_cfg (region_cfg)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_REGIONS; g++) begin : g_region
            ncd_region_match u_match (
                .cfg  (region_cfg[g]),
                .addr (lookup_addr),
                .hit  (region_hit[g])
            );

            // R5
            size_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (region_cfg[g].base_code[3:0] == CODE_OFF) |-> !region_hit[g])
                else $error("disabled region %0d matched", g);

            // R7
            size_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (region_cfg[g].base_code[3:0] == CODE_ALL) |-> region_hit[g])
                else $error("full-space region %0d missed", g);
        end
    endgenerate

    ncd_legacy_match u_legacy (
        .low64k_en  (low64k_en),
        .hole_en    (hole_en),
        .addr_hi    (lookup_addr[ADDR_W-1:16]),
        .low64k_hit (low64k_hit),
        .hole_hit   (hole_hit)
    );

    // Merge every source of a non-cacheable verdict.
    always_comb begin
        any_region_hit = |region_hit;
        uncached_d     = any_region_hit | low64k_hit | hole_hit;
    end

    // Output register: one cycle from address to flag.
    always_ff @(posedge clk) begin
        if (!rst_n) lookup_uncached <= 1'b0;
        else        lookup_uncached <= uncached_d;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> !lookup_uncached)
        else $error("output not cleared by reset");

    // R10
    region_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_region_hit |=> lookup_uncached)
        else $error("region hit not reflected one cycle later");

    // R8
    low64k_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low64k_hit |=> lookup_uncached)
        else $error("low 64 KB hit not reflected");

    // R9
    hole_absolute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_addr[ADDR_W-1:20] != '0) |-> !hole_hit)
        else $error("legacy hole matched above the first megabyte");
endmodule

// File: tb/nc_region_decoder_tb.sv
// Bench: behavioural reference model compared on every falling edge, plus
// directed read-back and lookup checks with hand-computed expectations.
module nc_region_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_idx = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic [31:0] lookup_addr = 32'h0;
    logic        lookup_uncached;

    int    errors = 0;
    int    checks = 0;
    logic [7:0] m_regs [0:255];
    logic  exp_q = 1'b0;
    string cur_tag = "R10";
    string exp_tag = "R10";
    bit    started = 1'b0;
    bit    done = 1'b0;

    always #10 clk = ~clk;

    nc_region_decoder u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_wr_en       (cfg_wr_en),
        .cfg_idx         (cfg_idx),
        .cfg_wdata       (cfg_wdata),
        .cfg_rdata       (cfg_rdata),
        .lookup_addr     (lookup_addr),
        .lookup_uncached (lookup_uncached)
    );

    function automatic bit stored_idx(input logic [7:0] i);
        return (i == 8'hC0) || (i == 8'hC1) || (i >= 8'hC4 && i <= 8'hCF);
    endfunction

    function automatic logic ref_nc(input logic [31:0] a);
        logic r = 1'b0;
        for (int g = 0; g < 4; g++) begin
            int unsigned bi = 32'hC4 + 3 * g;
            longint unsigned base = {m_regs[bi], m_regs[bi+1], m_regs[bi+2][7:4], 12'h000};
            int unsigned code = m_regs[bi+2][3:0];
            if (code == 15) r = 1'b1;
            else if (code != 0) begin
                longint unsigned span = 64'd1 << (code + 11);
                if ((longint'(a) / span) == (base / span)) r = 1'b1;
            end
        end
        if (m_regs[8'hC0][0] && ((a >> 16) % 16 == 0)) r = 1'b1;
        if (m_regs[8'hC0][1] && a >= 32'h000A0000 && a <= 32'h000FFFFF) r = 1'b1;
        return r;
    endfunction

    // Reference model: capture the expectation, then apply any write.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) m_regs[i] = 8'h00;
            exp_q   <= 1'b0;
            exp_tag <= "R1";
        end else begin
            exp_q   <= ref_nc(lookup_addr);
            exp_tag <= cur_tag;
            if (cfg_wr_en && stored_idx(cfg_idx))
                m_regs[cfg_idx] = (cfg_idx == 8'hC1) ? (cfg_wdata & 8'h01) : cfg_wdata;
        end
        started <= 1'b1;
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (lookup_uncached !== exp_q) begin
                errors++;
                $display("FAIL %s model compare: lookup_uncached=%0b expected=%0b", exp_tag, lookup_uncached, exp_q);
            end
        end
    end

    task automatic wr(input logic [7:0] i, input logic [7:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_idx = i; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic rd_check(input logic [7:0] i, input logic [7:0] expv, input string tag);
        @(negedge clk);
        cfg_idx = i;
        #1;
        checks++;
        if (cfg_rdata !== expv || cfg_rdata !== m_regs[i]) begin
            errors++;
            $display("FAIL %s readback idx=%h: actual=%h expected=%h", tag, i, cfg_rdata, expv);
        end
    endtask

    task automatic look(input logic [31:0] a, input logic expv, input string tag);
        @(negedge clk);
        lookup_addr = a; cur_tag = tag;
        @(negedge clk);
        #1;
        checks++;
        if (lookup_uncached !== expv) begin
            errors++;
            $display("FAIL %s lookup %h: actual=%0b expected=%0b", tag, a, lookup_uncached, expv);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: everything reads zero and nothing is non-cacheable
        rd_check(8'hC0, 8'h00, "R1");
        rd_check(8'hC1, 8'h00, "R1");
        for (int i = 8'hC4; i <= 8'hCF; i++) rd_check(8'(i), 8'h00, "R1");
        look(32'h0000_0000, 1'b0, "R1");
        look(32'h000A_0000, 1'b0, "R1");

        // R5: region 0 programmed with size code 0 stays inactive
        wr(8'hC4, 8'h12); wr(8'hC5, 8'h34); wr(8'hC6, 8'h80);
        look(32'h1234_8000, 1'b0, "R5");
        look(32'h1234_0000, 1'b0, "R5");

        // R6: 32 KB block at 0x12348000 (code 4)
        wr(8'hC6, 8'h84);
        look(32'h1234_8000, 1'b1, "R6");
        look(32'h1234_FFFF, 1'b1, "R6");
        look(32'h1235_0000, 1'b0, "R6");
        look(32'h1234_7FFF, 1'b0, "R6");

        // R2: rewrite only the middle byte of region 0
        wr(8'hC5, 8'h35);
        rd_check(8'hC4, 8'h12, "R2");
        rd_check(8'hC5, 8'h35, "R2");
        rd_check(8'hC6, 8'h84, "R2");
        look(32'h1235_8000, 1'b1, "R2");
        look(32'h1234_8000, 1'b0, "R2");

        // R6: 32 MB block (code 14) and 4 KB block (code 1)
        wr(8'hC7, 8'h02); wr(8'hC8, 8'h00); wr(8'hC9, 8'h0E);
        look(32'h03FF_FFFF, 1'b1, "R6");
        look(32'h0400_0000, 1'b0, "R6");
        look(32'h01FF_FFFF, 1'b0, "R6");
        wr(8'hCD, 8'h7F); wr(8'hCE, 8'hFF); wr(8'hCF, 8'hF1);
        look(32'h7FFF_F800, 1'b1, "R6");
        look(32'h7FFF_E000, 1'b0, "R6");
        look(32'h8000_0000, 1'b0, "R6");
        rd_check(8'hCA, 8'h00, "R2");

        // R7: code 15 covers all of memory, then switched off
        wr(8'hCC, 8'h0F);
        look(32'hDEAD_BEEF, 1'b1, "R7");
        look(32'h0000_0000, 1'b1, "R7");
        wr(8'hCC, 8'h00);
        look(32'hDEAD_BEEF, 1'b0, "R7");

        // R4: unknown indices ignored
        wr(8'hC2, 8'hFF); wr(8'hC3, 8'hFF); wr(8'hD0, 8'hFF);
        wr(8'hBF, 8'hFF); wr(8'h00, 8'hFF);
        rd_check(8'hC2, 8'h00, "R4");
        rd_check(8'hC3, 8'h00, "R4");
        rd_check(8'hD0, 8'h00, "R4");
        rd_check(8'hC0, 8'h00, "R4");
        rd_check(8'hC1, 8'h00, "R4");
        look(32'h0000_0000, 1'b0, "R4");
        look(32'h000A_0000, 1'b0, "R4");

        // R3: reserved auxiliary bits
        wr(8'hC1, 8'hFF);
        rd_check(8'hC1, 8'h01, "R3");
        wr(8'hC1, 8'hFE);
        rd_check(8'hC1, 8'h00, "R3");

        // R8: low 64 KB of every megabyte
        wr(8'hC0, 8'h01);
        look(32'h0030_FFFF, 1'b1, "R8");
        look(32'h0031_0000, 1'b0, "R8");
        look(32'hFFF0_0000, 1'b1, "R8");

        // R9: absolute legacy hole
        wr(8'hC0, 8'h02);
        look(32'h000A_0000, 1'b1, "R9");
        look(32'h0009_FFFF, 1'b0, "R9");
        look(32'h000F_FFFF, 1'b1, "R9");
        look(32'h001A_0000, 1'b0, "R9");
        look(32'h0000_0000, 1'b0, "R9");

        // R10: back-to-back addresses, one-cycle latency
        @(negedge clk); lookup_addr = 32'h000A_0000; cur_tag = "R10";
        @(negedge clk); lookup_addr = 32'h0009_FFFF;
        #1; checks++;
        if (lookup_uncached !== 1'b1) begin
            errors++;
            $display("FAIL R10 first of pair: actual=%0b expected=1", lookup_uncached);
        end
        @(negedge clk); #1; checks++;
        if (lookup_uncached !== 1'b0) begin
            errors++;
            $display("FAIL R10 second of pair: actual=%0b expected=0", lookup_uncached);
        end

        // R10: mixed random traffic against the model
        for (int n = 0; n < 600; n++) begin
            @(negedge clk);
            cur_tag = "R10";
            cfg_wr_en = 1'b0;
            if ($urandom_range(0, 9) == 0) begin
                cfg_wr_en = 1'b1;
                cfg_idx   = 8'(8'hC0 + $urandom_range(0, 15));
                cfg_wdata = 8'($urandom);
                if (cfg_idx >= 8'hC4 && ((cfg_idx - 8'hC4) % 3 == 2) && cfg_wdata[3:0] == 4'hF)
                    cfg_wdata[3:0] = 4'h5;
            end
            if ($urandom_range(0, 1) == 0) begin
                int g = $urandom_range(0, 3);
                lookup_addr = {m_regs[8'(8'hC4 + 3*g)], m_regs[8'(8'hC5 + 3*g)], 16'($urandom)};
            end else begin
                lookup_addr = $urandom;
            end
        end
        @(negedge clk); cfg_wr_en = 1'b0;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule